// File: doc/BRIEF.md
# Scrambled MLT-3 Line Coder (Transmit)

This block is the transmit end of a 100BASE-TX-style physical coding path. An upstream block-code encoder hands it 5-bit code groups through a valid/ready handshake. The block shifts each group out one bit per clock and combines every outgoing bit by XOR with one bit of a key stream. The key stream comes from an 11-stage linear feedback generator. The block then maps the scrambled NRZ bits onto a three-level MLT-3 line code, given as a 2-bit level for the analog driver.

The clock is the bit clock. With groups offered back to back, the block accepts one group every five cycles and sends a steady bit stream. If the upstream side has no group ready, the serial stream pauses. During a pause the key generator and the line level both hold, so the scrambled sequence carries on where it stopped once data comes back.

Top module: `mlt3_scrambler_tx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `line_level` is 2'b00 and `grp_ready` is 1. Reset also loads the key generator with all ones.
- R2: A group is taken at a rising edge where `grp_valid` and `grp_ready` are both 1. `grp_ready` is then 0 for the next four cycles and 1 in the cycle that carries the group's last bit, so groups can follow one another with no gap. `grp_valid` has no effect while `grp_ready` is 0.
- R3: A group is sent most significant bit first, so bit 4 goes out first and bit 0 goes out last.
- R4: The key generator keeps the last 11 key bits. Each new key bit is X[n] = X[n-11] XOR X[n-9]. The generator never reaches the all-zero state.
- R5: Each transmitted bit is the plain bit XOR the newest key bit. The key generator moves on once per transmitted bit and does not move while no bit is being sent.
- R6: `line_level` uses the codes 2'b01 for positive, 2'b00 for zero and 2'b11 for negative, and never takes 2'b10. A scrambled 1 moves the level one step along the cycle 0, +1, 0, -1, 0. A scrambled 0 leaves the level unchanged. The first 1 after reset goes to +1.
- R7: For a group taken at edge P, the level that results from its k-th bit (k = 1 to 5) is visible after edge P+k.
- R8: While no group is being sent, `line_level` holds its value and `grp_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_valid | input | 1 | Upstream offers a code group |
| grp_data | input | 5 | Code group, bit 4 is sent first |
| grp_ready | output | 1 | Block can take a group at this edge |
| line_level | output | 2 | MLT-3 level: 01 positive, 00 zero, 11 negative |

## Verification
The checker tests on every cycle the rules that can be seen locally. The line code never takes the unused value and never jumps from one nonzero level to the other. The level and the key state both hold while no bit is sent. The key state is never all zeros. `grp_ready` drops after each accepted group. Whether the key stream follows the feedback equation, whether the bits go out MSB first, and what the exact latency is can only be shown by the bench scenarios. They compare every line level against an independent model over zero, one-filled and mixed groups. They also cover pauses and a reset in the middle of a stream.

// File: rtl/mlt3_tx_pkg.sv
// Package: shared parameters and the line-level type for the scrambled
// MLT-3 transmit path. Assumes a two-bit signed level code at the driver.
package mlt3_tx_pkg;

    localparam int GROUP_W = 5;   // bits per code group
    localparam int KEY_W   = 11;  // key generator length
    localparam int KEY_TAP = 9;   // second feedback distance

    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b11
    } line_lvl_e;

endpackage

// File: rtl/mlt3_group_shifter.sv
// Module: parallel-to-serial stage. Takes one group on a valid/ready
// handshake and sends it MSB first, one bit per clock.
// Assumes the clock is the bit clock. ready is high while idle and in the
// cycle of the last bit, which lets groups follow one another with no gap.
module mlt3_group_shifter #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ready,
    output logic             bit_vld,
    output logic             bit_val
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    logic [WIDTH-1:0] shreg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             take;

    // Purpose: raise ready when idle or when the last bit is going out
    always_comb begin
        in_ready = !busy_q || (cnt_q == LAST);
        take     = in_valid && in_ready;
    end

    // Purpose: load a new group or shift the current one toward the MSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
        end else if (take) begin
            shreg_q <= in_data;
            cnt_q   <= '0;
            busy_q  <= 1'b1;
        end else if (busy_q) begin
            shreg_q <= {shreg_q[WIDTH-2:0], 1'b0};
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Purpose: present the current MSB as the serial bit
    always_comb begin
        bit_vld = busy_q;
        bit_val = shreg_q[WIDTH-1];
    end

endmodule

// File: rtl/mlt3_keystream.sv
// Module: additive scrambler. An LFSR with taps at distances LEN and TAP
// produces one key bit per transmitted bit. The key bit is XORed into the
// data bit. Assumes TAP < LEN. Reset seeds all ones so the state is never zero.
module mlt3_keystream #(
    parameter int LEN = 11,
    parameter int TAP = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic           plain,
    output logic           scr,
    output logic [LEN-1:0] state
);
    logic [LEN-1:0] key_q;
    logic           key_new;

    // Purpose: form the new key bit from the two tapped history bits
    always_comb begin
        key_new = key_q[LEN-1] ^ key_q[TAP-1];
        scr     = plain ^ key_new;
        state   = key_q;
    end

    // Purpose: shift the history only when a bit is actually transmitted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '1;
        end else if (adv) begin
            key_q <= {key_q[LEN-2:0], key_new};
        end
    end

endmodule

// File: rtl/mlt3_level_enc.sv
// Module: MLT-3 state machine. A 1 steps the level around 0,+1,0,-1. A 0
// holds it. Remembers the sign of the last nonzero level. Assumes the
// reset direction makes the first step positive.
module mlt3_level_enc
    import mlt3_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_vld,
    input  logic      bit_val,
    output line_lvl_e level
);
    line_lvl_e lvl_q;
    logic      last_neg_q;

    // Purpose: advance the three-level state on each scrambled 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q      <= LVL_ZERO;
            last_neg_q <= 1'b1;
        end else if (bit_vld && bit_val) begin
            case (lvl_q)
                LVL_ZERO: begin
                    lvl_q      <= last_neg_q ? LVL_POS : LVL_NEG;
                    last_neg_q <= !last_neg_q;
                end
                default: lvl_q <= LVL_ZERO;
            endcase
        end
    end

    // Purpose: drive the registered level out
    always_comb level = lvl_q;

endmodule

// File: rtl/mlt3_scrambler_tx.sv
// Module: top of the transmit line coder: group shifter, key-stream
// scrambler, MLT-3 encoder. Assumes clk is the bit clock and that the
// upstream side keeps to the valid/ready handshake.
module mlt3_scrambler_tx
    import mlt3_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grp_valid,
    input  logic [GROUP_W-1:0] grp_data,
    output logic               grp_ready,
    output logic [1:0]         line_level
);
    logic             bit_vld;
    logic             bit_plain;
    logic             bit_scr;
    logic [KEY_W-1:0] key_state;
    line_lvl_e        lvl;

    mlt3_group_shifter #(.WIDTH(GROUP_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (grp_valid),
        .in_data  (grp_data),
        .in_ready (grp_ready),
        .bit_vld  (bit_vld),
        .bit_val  (bit_plain)
    );

    mlt3_keystream #(.LEN(KEY_W), .TAP(KEY_TAP)) u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (bit_vld),
        .plain (bit_plain),
        .scr   (bit_scr),
        .state (key_state)
    );

    mlt3_level_enc u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .bit_val (bit_scr),
        .level   (lvl)
    );

    // Purpose: expose the level code on the port
    always_comb line_level = lvl;

endmodule

// File: rtl/mlt3_tx_checker.sv
// Module: assertion checker bound to the transmit line coder.
module mlt3_tx_checker
    import mlt3_tx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             grp_valid,
    input logic             grp_ready,
    input logic [1:0]       line_level,
    input logic             bit_vld,
    input logic [KEY_W-1:0] key_state
);
    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        line_level != 2'b10); // R6
    AST_NO_SIGN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_level != 2'b00) |=> (line_level == $past(line_level) || line_level == 2'b00)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(line_level)); // R8
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |-> grp_ready); // R8
    AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(key_state)); // R5
    AST_KEY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        key_state != '0); // R4
    AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && grp_ready) |=> !grp_ready); // R2
endmodule

bind mlt3_scrambler_tx mlt3_tx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp_valid  (grp_valid),
    .grp_ready  (grp_ready),
    .line_level (line_level),
    .bit_vld    (bit_vld),
    .key_state  (key_state)
);

// File: tb/sim_mlt3_scrambler_tx.sv
module sim_mlt3_scrambler_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       grp_valid = 1'b0;
    logic [4:0] grp_data = '0;
    logic       grp_ready;
    logic [1:0] line_level;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [10:0] m_key;
    int          m_lvl;
    bit          m_last_neg;
    logic [4:0]  gq [0:15];

    mlt3_scrambler_tx u0 (
        .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid),
        .grp_data(grp_data), .grp_ready(grp_ready), .line_level(line_level)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [1:0] enc(int l);
        return (l > 0) ? 2'b01 : (l < 0) ? 2'b11 : 2'b00;
    endfunction

    task automatic model_reset();
        m_key = '1; m_lvl = 0; m_last_neg = 1'b1;
    endtask

    // one transmitted bit: key X[n]=X[n-11]^X[n-9], then MLT-3 step
    task automatic model_bit(bit p);
        bit x, s;
        x = m_key[10] ^ m_key[8];
        m_key = {m_key[9:0], x};
        s = p ^ x;
        if (s) begin
            if (m_lvl != 0) m_lvl = 0;
            else if (m_last_neg) begin m_lvl = 1; m_last_neg = 1'b0; end
            else begin m_lvl = -1; m_last_neg = 1'b1; end
        end
    endtask

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Sends n groups back to back from gq; call just after a negedge
    task automatic run_burst(int n, string tag);
        for (int c = 0; c <= 5*n + 3; c++) begin
            check({tag, " R2 ready"}, {1'b0, grp_ready},
                  {1'b0, (c >= 5*n) || (c % 5 == 0)});
            if (c < 5*n) begin
                grp_valid = 1'b1;
                grp_data  = gq[c/5];
            end else begin
                grp_valid = 1'b0;
                grp_data  = 5'h15;
            end
            @(posedge clk); @(negedge clk);
            if (c >= 1 && c <= 5*n)
                model_bit(gq[(c-1)/5][4-((c-1)%5)]);   // R3 MSB first
            check({tag, " R7 level"}, line_level, enc(m_lvl));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; grp_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 level in reset", line_level, 2'b00);
        check("R1 ready in reset", {1'b0, grp_ready}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 level after reset", line_level, 2'b00);
        model_reset();
    endtask

    task automatic t_zero_groups();   // R4 R5: key stream alone drives the level
        for (int i = 0; i < 8; i++) gq[i] = 5'b00000;
        run_burst(8, "zeros R4");
    endtask

    task automatic t_idle_groups();   // R6: all-ones groups
        for (int i = 0; i < 6; i++) gq[i] = 5'b11111;
        run_burst(6, "ones R6");
    endtask

    task automatic t_mixed();         // R3: asymmetric groups expose bit order
        gq[0] = 5'b11000; gq[1] = 5'b10001; gq[2] = 5'b00111;
        gq[3] = 5'b01101; gq[4] = 5'b10000; gq[5] = 5'b00001;
        run_burst(6, "mixed R3");
    endtask

    task automatic t_pause();         // R5 R8: gap must not advance key or level
        logic [1:0] held;
        held = line_level;
        repeat (7) begin
            @(negedge clk);
            check("R8 hold in gap", line_level, held);
        end
        gq[0] = 5'b01010; gq[1] = 5'b00000;
        run_burst(2, "after gap R5");
    endtask

    task automatic t_mid_reset();     // R1: reset mid-stream reseeds generator
        grp_valid = 1'b1; grp_data = 5'b10110;
        repeat (3) @(negedge clk);
        do_reset();
        for (int i = 0; i < 4; i++) gq[i] = 5'b00000;
        run_burst(4, "reseed R1");
    endtask

    initial begin
        do_reset();
        t_zero_groups();
        t_idle_groups();
        t_mixed();
        t_pause();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule